// File: doc/BRIEF.md
# Four-Channel Debug Breakpoint Matcher

This block watches a processor's instruction-fetch and data-access addresses against four software-programmed breakpoint addresses. Each channel carries its own access-kind code, a span-length code and a pair of arming bits, one local and one global. A channel that is armed and matches raises a debug-exception request. Single-step completion and a task-switch trap indication raise the same request.

A sticky status register records every cause that fired, so that a debug handler can tell which condition stopped the program. Software clears or rewrites the status register through its write port. A resume flag suppresses instruction breakpoints while the faulting instruction is being restarted. The processor core delivers the exception itself.

The block has one clock and a synchronous active-high reset. Fetch breakpoints are evaluated before the instruction runs. Data breakpoints are evaluated as the access completes. Both kinds raise the request on the clock edge that samples the matching access.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset, `dbg_req` is 0, `dbg_status` is 0, all breakpoint addresses are 0 and the control register is 0, so no channel is armed.
- R2: Control bit 2i is the local enable and bit 2i+1 is the global enable of channel i. A channel can match only when at least one of its two enables is set.
- R3: The access-kind code of channel i sits at control bits [2*NCH+4i+1 : 2*NCH+4i]. Code 00 matches when `fetch_valid` is high and `fetch_addr` equals the channel's whole address.
- R4: Kind code 01 matches data writes (`data_wr`) only. A read alone does not match.
- R5: Kind code 11 matches data reads or data writes. It never matches an instruction fetch.
- R6: Kind code 10 never matches and leaves that channel's status bit untouched.
- R7: The length code of channel i sits at control bits [2*NCH+4i+3 : 2*NCH+4i+2] and applies to data matches. Code 00 compares all address bits, code 01 ignores bit 0, and code 11 ignores bits 1:0. Code 10 behaves as code 00.
- R8: While `resume_flag` is high, kind-00 channels do not match. Data channels are not affected by it.
- R9: When `step_flag` and `insn_done` are both high, status bit NCH is set and a request is raised.
- R10: A high `task_trap` sets status bit NCH+1 and raises a request.
- R11: Status bits 0..NCH-1 record the channels that matched. All status bits are sticky. A `stat_we` cycle replaces the status with `stat_wdata`, and any event in that same cycle is ORed into the written value.
- R12: `dbg_req` is registered. It is high in the cycle after a cycle holding at least one event, and low otherwise.
- R13: `areg_we` writes `areg_wdata` into the channel selected by `areg_sel`. `ctrl_we` loads `ctrl_wdata` into the control register. Both writes take effect for matching from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | input | ADDR_W | Instruction-fetch address |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| resume_flag | input | 1 | Restarted instruction; suppresses fetch breakpoints |
| data_addr | input | ADDR_W | Data-access address |
| data_rd | input | 1 | Data read completes this cycle |
| data_wr | input | 1 | Data write completes this cycle |
| insn_done | input | 1 | An instruction retires this cycle |
| step_flag | input | 1 | Single-step mode active |
| task_trap | input | 1 | Task switch into a trapping task |
| areg_we | input | 1 | Breakpoint address write strobe |
| areg_sel | input | $clog2(NCH) | Channel selected for the address write |
| areg_wdata | input | ADDR_W | Breakpoint address write data |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 6*NCH | Control register write data |
| stat_we | input | 1 | Status register write strobe |
| stat_wdata | input | NCH+2 | Status register write data |
| dbg_req | output | 1 | Registered debug-exception request |
| dbg_status | output | NCH+2 | Sticky cause bits |

## Verification
The bench builds the block with NCH=4 and ADDR_W=16. The narrow address width lets random fetch and data addresses land near the programmed breakpoints. Most random cycles draw an address that differs from a breakpoint only in its low three bits. This brings the ignored-bit windows of every length code, and the cases just outside them, within reach. Random control words visit every kind and length code, including the undefined ones, under every mix of local and global enables. These cycles overlap status writes with events in the same cycle.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;

  // access kind selected per channel
  typedef enum logic [1:0] {
    KIND_EXEC  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_RSVD  = 2'b10,
    KIND_RW    = 2'b11
  } acc_kind_e;

  // span length selected per channel
  typedef enum logic [1:0] {
    SPAN_1    = 2'b00,
    SPAN_2    = 2'b01,
    SPAN_RSVD = 2'b10,
    SPAN_4    = 2'b11
  } span_len_e;

  // control field widths per channel
  localparam int EN_BITS_PER_CH    = 2;
  localparam int FIELD_BITS_PER_CH = 4;

endpackage

// File: rtl/bkpt_addr_regs.sv
module bkpt_addr_regs #(
  parameter int ADDR_W = 32,
  parameter int NCH    = 4,
  localparam int SEL_W = $clog2(NCH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [SEL_W-1:0]           sel,
  input  logic [ADDR_W-1:0]          wdata,
  output logic [NCH-1:0][ADDR_W-1:0] addr_q
);

  for (genvar g = 0; g < NCH; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q[g] <= '0;
      end else if (we && (sel == SEL_W'(g))) begin
        addr_q[g] <= wdata;
      end
    end
  end

endmodule

// File: rtl/bkpt_channel.sv
module bkpt_channel
  import dbg_bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic              en_local,
  input  logic              en_global,
  input  acc_kind_e         kind,
  input  span_len_e         span,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_valid,
  input  logic              resume_flag,
  input  logic [ADDR_W-1:0] data_addr,
  input  logic              data_rd,
  input  logic              data_wr,
  output logic              hit
);

  logic [ADDR_W-1:0] cmp_mask;
  logic              armed;
  logic              data_eq;
  logic              fetch_eq;

  always_comb begin
    cmp_mask = '1;
    case (span)
      SPAN_2:  cmp_mask[0]   = 1'b0;
      SPAN_4:  cmp_mask[1:0] = 2'b00;
      default: cmp_mask      = '1;
    endcase
  end

  assign armed    = en_local | en_global;
  assign data_eq  = ((data_addr ^ bp_addr) & cmp_mask) == '0;
  assign fetch_eq = fetch_addr == bp_addr;

  always_comb begin
    hit = 1'b0;
    if (armed) begin
      case (kind)
        KIND_EXEC:  hit = fetch_valid && !resume_flag && fetch_eq;
        KIND_WRITE: hit = data_wr && data_eq;
        KIND_RW:    hit = (data_rd || data_wr) && data_eq;
        default:    hit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/bkpt_status.sv
module bkpt_status #(
  parameter int NCH = 4,
  localparam int STAT_W = NCH + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] events,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] status_q,
  output logic              req_q
);

  logic [STAT_W-1:0] base;

  assign base = wr_en ? wr_data : status_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      req_q    <= 1'b0;
    end else begin
      status_q <= base | events;
      req_q    <= |events;
    end
  end

endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
  import dbg_bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NCH    = 4,
  localparam int SEL_W  = $clog2(NCH),
  localparam int CTRL_W = (EN_BITS_PER_CH + FIELD_BITS_PER_CH) * NCH,
  localparam int STAT_W = NCH + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_valid,
  input  logic              resume_flag,
  input  logic [ADDR_W-1:0] data_addr,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic              insn_done,
  input  logic              step_flag,
  input  logic              task_trap,
  input  logic              areg_we,
  input  logic [SEL_W-1:0]  areg_sel,
  input  logic [ADDR_W-1:0] areg_wdata,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              stat_we,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic              dbg_req,
  output logic [STAT_W-1:0] dbg_status
);

  localparam int FIELD_BASE = EN_BITS_PER_CH * NCH;

  logic [NCH-1:0][ADDR_W-1:0] bp_addr;
  logic [CTRL_W-1:0]          ctrl_q;
  logic [NCH-1:0]             ch_hit;
  logic [STAT_W-1:0]          events;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_wdata;
    end
  end

  bkpt_addr_regs #(.ADDR_W(ADDR_W), .NCH(NCH)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (areg_we),
    .sel    (areg_sel),
    .wdata  (areg_wdata),
    .addr_q (bp_addr)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    bkpt_channel #(.ADDR_W(ADDR_W)) u_ch (
      .bp_addr     (bp_addr[g]),
      .en_local    (ctrl_q[EN_BITS_PER_CH*g]),
      .en_global   (ctrl_q[EN_BITS_PER_CH*g+1]),
      .kind        (acc_kind_e'(ctrl_q[FIELD_BASE+FIELD_BITS_PER_CH*g +: 2])),
      .span        (span_len_e'(ctrl_q[FIELD_BASE+FIELD_BITS_PER_CH*g+2 +: 2])),
      .fetch_addr  (fetch_addr),
      .fetch_valid (fetch_valid),
      .resume_flag (resume_flag),
      .data_addr   (data_addr),
      .data_rd     (data_rd),
      .data_wr     (data_wr),
      .hit         (ch_hit[g])
    );
  end

  assign events = {task_trap, step_flag & insn_done, ch_hit};

  bkpt_status #(.NCH(NCH)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .events   (events),
    .wr_en    (stat_we),
    .wr_data  (stat_wdata),
    .status_q (dbg_status),
    .req_q    (dbg_req)
  );

endmodule

// File: rtl/dbg_bkpt_checker.sv
module dbg_bkpt_checker #(
  parameter int NCH = 4,
  localparam int CTRL_W = 6 * NCH,
  localparam int STAT_W = NCH + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_valid,
  input logic              data_rd,
  input logic              data_wr,
  input logic              insn_done,
  input logic              step_flag,
  input logic              task_trap,
  input logic              stat_we,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              dbg_req,
  input logic [STAT_W-1:0] dbg_status
);

  // R9: a retired instruction under single-step raises the request and BS bit
  assert_step_req_R9: assert property (@(posedge clk) disable iff (rst)
    (step_flag && insn_done) |=> (dbg_req && dbg_status[NCH]));

  // R10: task-switch trap raises the request and its status bit
  assert_task_req_R10: assert property (@(posedge clk) disable iff (rst)
    task_trap |=> (dbg_req && dbg_status[NCH+1]));

  // R12: no access and no trap source means no request
  assert_quiet_no_req_R12: assert property (@(posedge clk) disable iff (rst)
    (!fetch_valid && !data_rd && !data_wr && !(step_flag && insn_done) && !task_trap)
    |=> !dbg_req);

  // R11: a request always leaves a recorded cause
  assert_req_has_cause_R11: assert property (@(posedge clk) disable iff (rst)
    dbg_req |-> (dbg_status != '0));

  // R11: without a software write no status bit ever clears
  assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    !stat_we |=> ((dbg_status & $past(dbg_status)) == $past(dbg_status)));

  // R6: a channel with the undefined kind code leaves its bit unchanged
  for (genvar g = 0; g < NCH; g++) begin : g_rsvd
    assert_rsvd_kind_silent_R6: assert property (@(posedge clk) disable iff (rst)
      ((ctrl_q[2*NCH+4*g +: 2] == 2'b10) && !stat_we)
      |=> (dbg_status[g] == $past(dbg_status[g])));
  end

endmodule

bind dbg_bkpt_unit dbg_bkpt_checker #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fetch_valid (fetch_valid),
  .data_rd     (data_rd),
  .data_wr     (data_wr),
  .insn_done   (insn_done),
  .step_flag   (step_flag),
  .task_trap   (task_trap),
  .stat_we     (stat_we),
  .ctrl_q      (ctrl_q),
  .dbg_req     (dbg_req),
  .dbg_status  (dbg_status)
);

// File: tb/dbg_bkpt_unit_test.sv
module dbg_bkpt_unit_test;
  localparam int AW = 16;
  localparam int NC = 4;
  localparam int CW = 6 * NC;
  localparam int SW = NC + 2;
  localparam int SELW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic [AW-1:0] fetch_addr, data_addr, areg_wdata;
  logic          fetch_valid, resume_flag, data_rd, data_wr;
  logic          insn_done, step_flag, task_trap;
  logic          areg_we, ctrl_we, stat_we;
  logic [SELW-1:0] areg_sel;
  logic [CW-1:0] ctrl_wdata;
  logic [SW-1:0] stat_wdata;
  logic          dbg_req;
  logic [SW-1:0] dbg_status;

  dbg_bkpt_unit #(.ADDR_W(AW), .NCH(NC)) uut (
    .clk(clk), .rst(rst),
    .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .resume_flag(resume_flag),
    .data_addr(data_addr), .data_rd(data_rd), .data_wr(data_wr),
    .insn_done(insn_done), .step_flag(step_flag), .task_trap(task_trap),
    .areg_we(areg_we), .areg_sel(areg_sel), .areg_wdata(areg_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .stat_we(stat_we), .stat_wdata(stat_wdata),
    .dbg_req(dbg_req), .dbg_status(dbg_status)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [AW-1:0] m_addr [NC];
  logic [CW-1:0] m_ctrl;
  logic [SW-1:0] m_stat;

  function automatic logic [SW-1:0] model_events();
    logic [SW-1:0] ev;
    ev = '0;
    for (int i = 0; i < NC; i++) begin
      logic armed;
      logic [1:0] ty, ln;
      logic [AW-1:0] lowm;
      logic deq;
      armed = m_ctrl[2*i] | m_ctrl[2*i+1];
      ty = m_ctrl[2*NC+4*i +: 2];
      ln = m_ctrl[2*NC+4*i+2 +: 2];
      lowm = (ln == 2'b01) ? AW'(1) : (ln == 2'b11) ? AW'(3) : '0;
      deq = (data_addr | lowm) == (m_addr[i] | lowm);
      if (armed) begin
        if (ty == 2'b00 && fetch_valid && !resume_flag && fetch_addr == m_addr[i]) ev[i] = 1'b1;
        if (ty == 2'b01 && data_wr && deq) ev[i] = 1'b1;
        if (ty == 2'b11 && (data_rd || data_wr) && deq) ev[i] = 1'b1;
      end
    end
    ev[NC]   = step_flag & insn_done;
    ev[NC+1] = task_trap;
    return ev;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fetch_addr = '0; fetch_valid = 0; resume_flag = 0;
    data_addr = '0; data_rd = 0; data_wr = 0;
    insn_done = 0; step_flag = 0; task_trap = 0;
    areg_we = 0; areg_sel = '0; areg_wdata = '0;
    ctrl_we = 0; ctrl_wdata = '0; stat_we = 0; stat_wdata = '0;
  endtask

  // inputs already driven; advance one cycle and compare with the model
  task automatic tick(input string tag);
    logic [SW-1:0] ev, nst;
    ev  = model_events();
    nst = (stat_we ? stat_wdata : m_stat) | ev;
    @(posedge clk);
    @(negedge clk);
    check({tag, " req"}, 32'(dbg_req), 32'(|ev));
    check({tag, " status"}, 32'(dbg_status), 32'(nst));
    if (areg_we) m_addr[areg_sel] = areg_wdata;
    if (ctrl_we) m_ctrl = ctrl_wdata;
    m_stat = nst;
    idle_inputs();
  endtask

  function automatic logic [CW-1:0] ch_fields(input int ch, input logic [1:0] ty,
                                              input logic [1:0] ln, input logic [1:0] en);
    logic [CW-1:0] v;
    v = '0;
    v[2*ch +: 2] = en;
    v[2*NC+4*ch +: 2] = ty;
    v[2*NC+4*ch+2 +: 2] = ln;
    return v;
  endfunction

  task automatic set_addr(input int ch, input logic [AW-1:0] a);
    areg_we = 1; areg_sel = SELW'(ch); areg_wdata = a; tick("R13 write");
  endtask

  task automatic set_ctrl(input logic [CW-1:0] v);
    ctrl_we = 1; ctrl_wdata = v; tick("R2 ctrl write");
  endtask

  task automatic clr_stat();
    stat_we = 1; stat_wdata = '0; tick("R11 clear");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] cfg;
    idle_inputs();
    for (int i = 0; i < NC; i++) m_addr[i] = '0;
    m_ctrl = '0; m_stat = '0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 req", 32'(dbg_req), 0);
    check("R1 status", 32'(dbg_status), 0);
    // R1: everything disarmed, fetch and data at address 0 must be silent
    fetch_valid = 1; data_wr = 1; data_rd = 1; tick("R1 disarmed");
    check("R1 no cause", 32'(dbg_status), 0);

    // R2 / R13: program channel 0 exec at 0x1234, still disarmed
    set_addr(0, 16'h1234);
    set_ctrl(ch_fields(0, 2'b00, 2'b00, 2'b00));
    fetch_valid = 1; fetch_addr = 16'h1234; tick("R2 unarmed");
    check("R2 unarmed status", 32'(dbg_status), 0);
    // R2: global enable only
    set_ctrl(ch_fields(0, 2'b00, 2'b00, 2'b10));
    fetch_valid = 1; fetch_addr = 16'h1234; tick("R3 exec hit");
    check("R3 B0 set", 32'(dbg_status[0]), 1);
    tick("R12 req drops");
    check("R12 req low", 32'(dbg_req), 0);
    clr_stat();
    // R3: neighbour address does not hit; R8: resume suppresses
    fetch_valid = 1; fetch_addr = 16'h1235; tick("R3 exec miss");
    fetch_valid = 1; fetch_addr = 16'h1234; resume_flag = 1; tick("R8 resume");
    check("R8 suppressed", 32'(dbg_status[0]), 0);

    // channel 1 write-only, 2-byte span; channel 2 rw 4-byte; channel 3 reserved kind
    set_addr(1, 16'h2000);
    set_addr(2, 16'h3004);
    set_addr(3, 16'h4000);
    cfg = ch_fields(0, 2'b00, 2'b00, 2'b01) | ch_fields(1, 2'b01, 2'b01, 2'b01)
        | ch_fields(2, 2'b11, 2'b11, 2'b11) | ch_fields(3, 2'b10, 2'b00, 2'b11);
    set_ctrl(cfg);
    data_rd = 1; data_addr = 16'h2001; tick("R4 read ignored");
    check("R4 B1 clear", 32'(dbg_status[1]), 0);
    data_wr = 1; data_addr = 16'h2001; tick("R7 span2 hit");
    check("R7 B1 set", 32'(dbg_status[1]), 1);
    clr_stat();
    data_wr = 1; data_addr = 16'h2002; tick("R7 span2 miss");
    data_rd = 1; data_addr = 16'h3007; tick("R5 read hit");
    check("R5 B2 set", 32'(dbg_status[2]), 1);
    clr_stat();
    data_wr = 1; data_addr = 16'h3008; tick("R7 span4 miss");
    fetch_valid = 1; fetch_addr = 16'h3004; tick("R5 fetch ignored");
    check("R5 fetch no B2", 32'(dbg_status[2]), 0);
    data_wr = 1; data_rd = 1; data_addr = 16'h4000; fetch_valid = 1; fetch_addr = 16'h4000;
    tick("R6 reserved kind");
    check("R6 B3 clear", 32'(dbg_status[3]), 0);
    // R8: data still matches while resuming
    resume_flag = 1; fetch_valid = 1; fetch_addr = 16'h1234; data_wr = 1; data_addr = 16'h2000;
    tick("R8 data under resume");
    check("R8 only B1", 32'(dbg_status), 32'h2);
    // R9, R10
    step_flag = 1; insn_done = 1; tick("R9 single step");
    check("R9 BS", 32'(dbg_status[NC]), 1);
    step_flag = 1; tick("R9 no retire");
    task_trap = 1; tick("R10 task trap");
    check("R10 BT", 32'(dbg_status[NC+1]), 1);
    // R11: write with simultaneous event merges
    stat_we = 1; stat_wdata = 6'h08; task_trap = 1; tick("R11 write merge");
    check("R11 merged", 32'(dbg_status), 32'h28);
    tick("R11 sticky");
    check("R11 kept", 32'(dbg_status), 32'h28);

    // random phase
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      int sel;
      logic [AW-1:0] base;
      sel = int'($urandom_range(NC - 1));
      base = m_addr[sel];
      case ($urandom_range(19))
        0: begin areg_we = 1; areg_sel = SELW'($urandom_range(NC - 1));
                 areg_wdata = AW'($urandom_range(3) * 16'h1000 + $urandom_range(31)); end
        1: begin ctrl_we = 1; ctrl_wdata = CW'($urandom); end
        2: begin stat_we = 1; stat_wdata = SW'($urandom); end
        default: ;
      endcase
      fetch_valid = ($urandom_range(2) == 0);
      fetch_addr  = ($urandom_range(3) == 0) ? AW'($urandom) : (base ^ AW'($urandom_range(3)));
      data_rd     = ($urandom_range(2) == 0);
      data_wr     = ($urandom_range(2) == 0);
      data_addr   = ($urandom_range(4) == 0) ? AW'($urandom) : (base ^ AW'($urandom_range(7)));
      resume_flag = ($urandom_range(4) == 0);
      step_flag   = ($urandom_range(5) == 0);
      insn_done   = ($urandom_range(1) == 0);
      task_trap   = ($urandom_range(15) == 0);
      tick("random R11 R12");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule